// File: doc/BRIEF.md
# Delay-Line Centroid Calibrator

This block tunes the receive and transmit delay-line codes of a double-data-rate serial flash PHY. It follows a start pulse. First it applies the default codes and asks for one read of a known test pattern. If that read fails, calibration stops at once and reports failure. If it passes, the block sweeps a coarse rectangular grid of code pairs inside a window given on its inputs. For each grid point it applies the codes, waits a programmable number of settle cycles, and issues a test request. The surrounding controller answers each request with a pass/fail result.

The block keeps running sums of the passing receive codes, the passing transmit codes and the number of passes. The final code pair is the rounded mean of the passing points. A single stray passing point outside the main passing region therefore barely moves the result. Every grid point also produces a 32-bit trace word for later inspection. The read-delay setting is held constant and is never searched. The sweep length depends only on the grid, so a run takes a fixed time.

Top module: `dll_grid_cal`

## Requirements
- R1: After reset and while idle, `rxCode` and `txCode` hold the defaults (32 and 32 with default parameters), and `testReq`, `done`, `fail` and `traceValid` are all low.
- R2: Following a start, the first request is made at the default codes. If the result is fail, `done` and `fail` are raised. No further request is made and no trace word is emitted.
- R3: Once the check passes, exactly one request is made per grid point. Transmit codes form the outer loop and receive codes the inner loop. Each loop starts at its low bound and advances by `gridStep` while the code stays at or below its high bound. A step of 0 acts as 1.
- R4: Each time the codes change during the sweep, `testReq` rises exactly `settleCycles`+1 cycles later. Both codes stay stable while `testReq` is high. `testReq` drops in the cycle after `testDone` is seen.
- R5: Each answered sweep request produces one `traceValid` pulse in sweep order. The trace word holds the result in bits 7:0 (0x01 pass, 0x00 fail), the receive code in bits 15:8, the transmit code in bits 23:16 and the read delay in bits 31:24.
- R6: When at least one point passes, `done` rises with `fail` low. Each output code equals floor((sum of passing codes + floor(passCount/2)) / passCount), computed separately for receive and transmit.
- R7: When no grid point passes, `done` and `fail` rise and both codes return to the defaults.
- R8: For runs with at least one passing point, the number of cycles from start to `done` depends only on the window, the step, the settle count and the response latency, and not on which points pass.
- R9: `rdDelay` always equals the read-delay parameter (2 by default).
- R10: A start pulse received while `busy` is high is ignored. The sweep and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (taken only when idle) |
| rxLo | input | 6 | Receive window low bound |
| rxHi | input | 6 | Receive window high bound |
| txLo | input | 6 | Transmit window low bound |
| txHi | input | 6 | Transmit window high bound |
| gridStep | input | 6 | Grid spacing for both axes |
| settleCycles | input | 8 | Extra wait cycles after a code change |
| testDone | input | 1 | Pattern test finished (one cycle) |
| testPass | input | 1 | Pattern test result, valid with testDone |
| testReq | output | 1 | Pattern test request, held until testDone |
| rxCode | output | 6 | Receive delay code applied to the PHY |
| txCode | output | 6 | Transmit delay code applied to the PHY |
| rdDelay | output | 8 | Fixed read-delay setting |
| traceValid | output | 1 | Trace word strobe |
| traceWord | output | 32 | Per-point log word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Run finished without a usable point |

## Verification
A corrupted grid index shows up as a wrong code byte in the very next trace word. It also changes the number of requests, which is visible before `done`. Errors in the pass sums or the count only show at the end of the run, as a wrong final code pair. So the bench checks the codes against a mean it computes itself over several pass maps, including a stray isolated point and a rounding tie. A fault in the settle counter or the handshake shifts the request rise within one grid point, and a per-request gap monitor catches it there.

// File: rtl/dllcal_pkg.sv
package dllcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_REQ,
    ST_EVAL,
    ST_DIVWAIT
  } calState_t;

  typedef struct packed {
    logic setDefault;
    logic initGrid;
    logic record;
    logic passBit;
    logic step;
    logic divStart;
    logic latchResult;
  } calStrobe_t;

endpackage

// File: rtl/dllcal_div.sv
module dllcal_div #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 13,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             done,
  output logic [OUT_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] q;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             ge;

  always_comb begin
    shifted = {rem[DEN_W-1:0], q[NUM_W-1]};
    ge      = shifted >= {1'b0, denom};
    diff    = shifted - {1'b0, denom};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        q   <= numer;
        cnt <= CNT_W'(NUM_W);
        run <= 1'b1;
      end else if (run) begin
        rem <= ge ? diff : shifted;
        q   <= {q[NUM_W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q[OUT_W-1:0];
endmodule

// File: rtl/dllcal_ctrl.sv
module dllcal_ctrl
  import dllcal_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                testDone,
  input  logic                testPass,
  input  logic                lastPoint,
  input  logic                anyPass,
  input  logic                divDone,
  output calStrobe_t          strb,
  output logic                testReq,
  output logic                busy,
  output logic                done,
  output logic                fail
);
  calState_t           state, nState;
  logic [SETTLE_W-1:0] cnt, nCnt;
  logic                probing, nProbing;
  logic                nDone, nFail;

  always_comb begin
    nState   = state;
    nCnt     = cnt;
    nProbing = probing;
    nDone    = done;
    nFail    = fail;
    strb     = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.setDefault = 1'b1;
          nState   = ST_SETTLE;
          nCnt     = '0;
          nProbing = 1'b1;
          nDone    = 1'b0;
          nFail    = 1'b0;
        end
      end
      ST_SETTLE: begin
        if (cnt == settleCycles) nState = ST_REQ;
        else nCnt = cnt + 1'b1;
      end
      ST_REQ: begin
        if (testDone) begin
          nCnt = '0;
          if (probing) begin
            if (testPass) begin
              strb.initGrid = 1'b1;
              nProbing = 1'b0;
              nState   = ST_SETTLE;
            end else begin
              nFail  = 1'b1;
              nDone  = 1'b1;
              nState = ST_IDLE;
            end
          end else begin
            strb.record  = 1'b1;
            strb.passBit = testPass;
            if (lastPoint) begin
              nState = ST_EVAL;
            end else begin
              strb.step = 1'b1;
              nState    = ST_SETTLE;
            end
          end
        end
      end
      ST_EVAL: begin
        if (!anyPass) begin
          strb.setDefault = 1'b1;
          nFail  = 1'b1;
          nDone  = 1'b1;
          nState = ST_IDLE;
        end else begin
          strb.divStart = 1'b1;
          nState = ST_DIVWAIT;
        end
      end
      ST_DIVWAIT: begin
        if (divDone) begin
          strb.latchResult = 1'b1;
          nDone  = 1'b1;
          nState = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      probing <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      state   <= nState;
      cnt     <= nCnt;
      probing <= nProbing;
      done    <= nDone;
      fail    <= nFail;
    end
  end

  assign testReq = (state == ST_REQ);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/dllcal_dpath.sv
module dllcal_dpath
  import dllcal_pkg::*;
#(
  parameter int             CODE_W   = 6,
  parameter logic [CODE_W-1:0] DEF_RX = 6'd32,
  parameter logic [CODE_W-1:0] DEF_TX = 6'd32,
  parameter logic [7:0]     RD_DELAY = 8'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic [CODE_W-1:0] rxLo,
  input  logic [CODE_W-1:0] rxHi,
  input  logic [CODE_W-1:0] txLo,
  input  logic [CODE_W-1:0] txHi,
  input  logic [CODE_W-1:0] gridStep,
  output logic [CODE_W-1:0] rxCode,
  output logic [CODE_W-1:0] txCode,
  output logic              lastPoint,
  output logic              anyPass,
  output logic              divDone,
  output logic              traceValid,
  output logic [31:0]       traceWord
);
  localparam int PT_W  = 2 * CODE_W + 1;
  localparam int SUM_W = PT_W + CODE_W;
  localparam int LANES = 2;

  logic [SUM_W-1:0]  rxSum, txSum;
  logic [PT_W-1:0]   passCnt;
  logic [CODE_W-1:0] stepEff;
  logic [CODE_W:0]   rxNext, txNext;
  logic              rxWrap, txWrap;

  logic [SUM_W-1:0]  laneNum  [LANES];
  logic [CODE_W-1:0] laneQuot [LANES];
  logic              laneDone [LANES];

  always_comb begin
    stepEff   = (gridStep == '0) ? CODE_W'(1) : gridStep;
    rxNext    = {1'b0, rxCode} + {1'b0, stepEff};
    txNext    = {1'b0, txCode} + {1'b0, stepEff};
    rxWrap    = rxNext > {1'b0, rxHi};
    txWrap    = txNext > {1'b0, txHi};
    lastPoint = rxWrap && txWrap;
    anyPass   = (passCnt != '0);
    laneNum[0] = rxSum + SUM_W'(passCnt >> 1);
    laneNum[1] = txSum + SUM_W'(passCnt >> 1);
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      dllcal_div #(
        .NUM_W(SUM_W),
        .DEN_W(PT_W),
        .OUT_W(CODE_W)
      ) uDiv (
        .clk  (clk),
        .rstN (rstN),
        .start(strb.divStart),
        .numer(laneNum[g]),
        .denom(passCnt),
        .done (laneDone[g]),
        .quot (laneQuot[g])
      );
    end
  endgenerate

  assign divDone = laneDone[0] && laneDone[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCode     <= DEF_RX;
      txCode     <= DEF_TX;
      rxSum      <= '0;
      txSum      <= '0;
      passCnt    <= '0;
      traceValid <= 1'b0;
      traceWord  <= '0;
    end else begin
      traceValid <= strb.record;
      if (strb.record) begin
        traceWord <= {RD_DELAY, 8'(txCode), 8'(rxCode), 7'd0, strb.passBit};
        if (strb.passBit) begin
          rxSum   <= rxSum + SUM_W'(rxCode);
          txSum   <= txSum + SUM_W'(txCode);
          passCnt <= passCnt + 1'b1;
        end
      end
      if (strb.setDefault) begin
        rxCode  <= DEF_RX;
        txCode  <= DEF_TX;
        rxSum   <= '0;
        txSum   <= '0;
        passCnt <= '0;
      end else if (strb.initGrid) begin
        rxCode <= rxLo;
        txCode <= txLo;
      end else if (strb.step) begin
        if (rxWrap) begin
          rxCode <= rxLo;
          txCode <= txNext[CODE_W-1:0];
        end else begin
          rxCode <= rxNext[CODE_W-1:0];
        end
      end else if (strb.latchResult) begin
        rxCode <= laneQuot[0];
        txCode <= laneQuot[1];
      end
    end
  end
endmodule

// File: rtl/dll_grid_cal.sv
module dll_grid_cal
  import dllcal_pkg::*;
#(
  parameter int                CODE_W   = 6,
  parameter int                SETTLE_W = 8,
  parameter logic [CODE_W-1:0] DEF_RX   = 6'd32,
  parameter logic [CODE_W-1:0] DEF_TX   = 6'd32,
  parameter logic [7:0]        RD_DELAY = 8'd2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CODE_W-1:0]   rxLo,
  input  logic [CODE_W-1:0]   rxHi,
  input  logic [CODE_W-1:0]   txLo,
  input  logic [CODE_W-1:0]   txHi,
  input  logic [CODE_W-1:0]   gridStep,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                testDone,
  input  logic                testPass,
  output logic                testReq,
  output logic [CODE_W-1:0]   rxCode,
  output logic [CODE_W-1:0]   txCode,
  output logic [7:0]          rdDelay,
  output logic                traceValid,
  output logic [31:0]         traceWord,
  output logic                busy,
  output logic                done,
  output logic                fail
);
  calStrobe_t strb;
  logic       lastPoint, anyPass, divDone;

  dllcal_ctrl #(.SETTLE_W(SETTLE_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .settleCycles(settleCycles),
    .testDone    (testDone),
    .testPass    (testPass),
    .lastPoint   (lastPoint),
    .anyPass     (anyPass),
    .divDone     (divDone),
    .strb        (strb),
    .testReq     (testReq),
    .busy        (busy),
    .done        (done),
    .fail        (fail)
  );

  dllcal_dpath #(
    .CODE_W  (CODE_W),
    .DEF_RX  (DEF_RX),
    .DEF_TX  (DEF_TX),
    .RD_DELAY(RD_DELAY)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxLo      (rxLo),
    .rxHi      (rxHi),
    .txLo      (txLo),
    .txHi      (txHi),
    .gridStep  (gridStep),
    .rxCode    (rxCode),
    .txCode    (txCode),
    .lastPoint (lastPoint),
    .anyPass   (anyPass),
    .divDone   (divDone),
    .traceValid(traceValid),
    .traceWord (traceWord)
  );

  assign rdDelay = RD_DELAY;
endmodule

// File: rtl/dllcal_chk.sv
module dllcal_chk #(
  parameter int                CODE_W = 6,
  parameter logic [CODE_W-1:0] DEF_RX = 6'd32,
  parameter logic [CODE_W-1:0] DEF_TX = 6'd32
) (
  input logic              clk,
  input logic              rstN,
  input logic              testReq,
  input logic              testDone,
  input logic [CODE_W-1:0] rxCode,
  input logic [CODE_W-1:0] txCode,
  input logic              traceValid,
  input logic              busy,
  input logic              done,
  input logic              fail
);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !testReq);

  a_r4_codes_stable: assert property (@(posedge clk) disable iff (!rstN)
    testReq |-> ($stable(rxCode) && $stable(txCode)));

  a_r4_req_release: assert property (@(posedge clk) disable iff (!rstN)
    (testReq && testDone) |=> !testReq);

  a_r5_trace_after_answer: assert property (@(posedge clk) disable iff (!rstN)
    traceValid |-> $past(testReq && testDone));

  a_r7_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done);

  a_r7_fail_defaults: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (rxCode == DEF_RX && txCode == DEF_TX));
endmodule

bind dll_grid_cal dllcal_chk #(
  .CODE_W(CODE_W),
  .DEF_RX(DEF_RX),
  .DEF_TX(DEF_TX)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .testReq   (testReq),
  .testDone  (testDone),
  .rxCode    (rxCode),
  .txCode    (txCode),
  .traceValid(traceValid),
  .busy      (busy),
  .done      (done),
  .fail      (fail)
);

// File: tb/sim_dll_grid_cal.sv
`timescale 1ns/1ps
module sim_dll_grid_cal;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  rxLo = '0, rxHi = '0, txLo = '0, txHi = '0, gridStep = 6'd1;
  logic [7:0]  settleCycles = '0;
  logic        testDone = 1'b0, testPass = 1'b0;
  logic        testReq, traceValid, busy, done, fail;
  logic [5:0]  rxCode, txCode;
  logic [7:0]  rdDelay;
  logic [31:0] traceWord;

  always #5 clk = ~clk;

  dll_grid_cal u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .rxLo(rxLo), .rxHi(rxHi), .txLo(txLo), .txHi(txHi),
    .gridStep(gridStep), .settleCycles(settleCycles),
    .testDone(testDone), .testPass(testPass),
    .testReq(testReq), .rxCode(rxCode), .txCode(txCode), .rdDelay(rdDelay),
    .traceValid(traceValid), .traceWord(traceWord),
    .busy(busy), .done(done), .fail(fail)
  );

  int checks = 0;
  int failures = 0;

  // bench-side stimulus settings and observations
  int  mapMode = 0;
  bit  probeOk = 1'b1;
  int  latency = 1;
  int  reqIdx = 0;
  int  waitCnt = 0;
  int  sinceChange = 0;
  int  gapErr = 0;
  bit  prevReq = 1'b0;
  logic [5:0] prevRx = 6'd32, prevTx = 6'd32;
  logic [31:0] trc [512];
  int  trcCnt = 0;
  int  runCycles = 0;

  logic [31:0] expW [512];
  int  expCnt;
  int  expRx, expTx;
  bit  expAny;

  function automatic bit mapPass(input int m, input int rx, input int tx);
    case (m)
      0: return (rx >= 8 && rx <= 28 && tx >= 12 && tx <= 40);
      1: return ((rx >= 20 && rx <= 44 && tx >= 16 && tx <= 32) || (rx == 0 && tx == 0));
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // PHY/controller model plus monitors, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rxCode !== prevRx || txCode !== prevTx) sinceChange = 0;
      else sinceChange++;
      prevRx = rxCode;
      prevTx = txCode;
      if (testReq && !prevReq && reqIdx > 0 && sinceChange != int'(settleCycles) + 1) gapErr++;
      prevReq = testReq;
      if (traceValid && trcCnt < 512) begin
        trc[trcCnt] = traceWord;
        trcCnt++;
      end
      if (testDone) begin
        testDone = 1'b0;
      end else if (testReq) begin
        waitCnt++;
        if (waitCnt >= latency) begin
          testPass = (reqIdx == 0) ? probeOk : mapPass(mapMode, rxCode, txCode);
          testDone = 1'b1;
          reqIdx++;
          waitCnt = 0;
        end
      end
    end
  end

  task automatic buildExp(input int m);
    int sRx = 0, sTx = 0, cnt = 0;
    int stp = (gridStep == 0) ? 1 : int'(gridStep);
    expCnt = 0;
    for (int tx = txLo; tx <= txHi; tx += stp) begin
      for (int rx = rxLo; rx <= rxHi; rx += stp) begin
        bit p = mapPass(m, rx, tx);
        expW[expCnt] = {8'd2, 8'(tx), 8'(rx), 7'd0, p};
        expCnt++;
        if (p) begin sRx += rx; sTx += tx; cnt++; end
      end
    end
    expAny = (cnt != 0);
    expRx = expAny ? (sRx + cnt / 2) / cnt : 32;
    expTx = expAny ? (sTx + cnt / 2) / cnt : 32;
  endtask

  task automatic runCal(input bit pOk, input int m, input int rl, input int rh,
                        input int tl, input int th, input int st, input int se,
                        input int lat, input int midStart);
    int n = 0;
    @(negedge clk);
    probeOk = pOk; mapMode = m; latency = lat;
    rxLo = 6'(rl); rxHi = 6'(rh); txLo = 6'(tl); txHi = 6'(th);
    gridStep = 6'(st); settleCycles = 8'(se);
    reqIdx = 0; trcCnt = 0; gapErr = 0; waitCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 100000) begin
      @(negedge clk);
      n++;
      if (n == midStart) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    runCycles = n;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic compareTrace(input string tag);
    check(trcCnt == expCnt, {tag, " trace count"}, trcCnt, expCnt);
    for (int i = 0; i < expCnt && i < trcCnt; i++)
      check(trc[i] == expW[i], {tag, " trace word"}, trc[i], expW[i]);
  endtask

  task automatic t_reset;
    check(rxCode == 6'd32, "R1 reset rxCode", rxCode, 32);
    check(txCode == 6'd32, "R1 reset txCode", txCode, 32);
    check(!testReq && !done && !fail && !traceValid && !busy, "R1 reset quiet",
          {testReq, done, fail, traceValid, busy}, 0);
    check(rdDelay == 8'd2, "R9 read delay", rdDelay, 2);
  endtask

  task automatic t_rect;
    runCal(1, 0, 0, 60, 0, 60, 4, 3, 2, 200);
    buildExp(0);
    compareTrace("R5 R3 rect");
    check(reqIdx == expCnt + 1, "R3 request count", reqIdx, expCnt + 1);
    check(gapErr == 0, "R4 settle gap", gapErr, 0);
    check(done && !fail, "R6 rect done", {done, fail}, 2);
    check(rxCode == 6'(expRx), "R6 rect rx", rxCode, expRx);
    check(txCode == 6'(expTx), "R6 rect tx", txCode, expTx);
    check(trcCnt == expCnt, "R10 mid-run start ignored", trcCnt, expCnt);
    check(rdDelay == 8'd2, "R9 read delay after run", rdDelay, 2);
  endtask

  task automatic t_singular;
    int c0;
    runCal(1, 1, 0, 63, 0, 63, 6, 0, 1, 0);
    buildExp(1);
    compareTrace("R5 singular");
    check(gapErr == 0, "R4 settle zero", gapErr, 0);
    check(rxCode == 6'(expRx), "R6 singular rx", rxCode, expRx);
    check(txCode == 6'(expTx), "R6 singular tx", txCode, expTx);
    c0 = runCycles;
    runCal(1, 3, 0, 63, 0, 63, 6, 0, 1, 0);
    check(runCycles == c0, "R8 fixed duration", runCycles, c0);
  endtask

  task automatic t_round;
    runCal(1, 3, 10, 11, 20, 20, 1, 1, 3, 0);
    buildExp(3);
    check(rxCode == 6'd11, "R6 tie rounds up rx", rxCode, 11);
    check(txCode == 6'd20, "R6 tie tx", txCode, 20);
    runCal(1, 3, 5, 9, 7, 7, 0, 2, 1, 0);
    buildExp(3);
    compareTrace("R3 step zero");
    check(rxCode == 6'(expRx), "R6 step zero rx", rxCode, expRx);
  endtask

  task automatic t_probeFail;
    runCal(0, 3, 0, 20, 0, 20, 4, 1, 1, 0);
    check(done && fail, "R2 probe fail flags", {done, fail}, 3);
    check(trcCnt == 0, "R2 no trace", trcCnt, 0);
    check(reqIdx == 1, "R2 single request", reqIdx, 1);
    check(rxCode == 6'd32 && txCode == 6'd32, "R2 default codes", {rxCode, txCode}, {6'd32, 6'd32});
  endtask

  task automatic t_noPass;
    runCal(1, 2, 10, 30, 10, 30, 5, 2, 2, 0);
    buildExp(2);
    compareTrace("R7 no pass");
    check(done && fail, "R7 fail flags", {done, fail}, 3);
    check(rxCode == 6'd32 && txCode == 6'd32, "R7 default codes", {rxCode, txCode}, {6'd32, 6'd32});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rect();
    t_singular();
    t_round();
    t_probeFail();
    t_noPass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1900000;
    failures++;
    checks++;
    $display("FAIL watchdog global actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule